// File: doc/BRIEF.md
# Proportional-Integral Loop Filter with Extra Pole for a Digital PLL

This block is the digital loop filter of an all-digital phase-locked loop. It runs on the reference clock, nominally 50 MHz, and takes one signed phase-error code per cycle from a time-to-digital converter. One code is one delay-element step, about 20 ps. From each code it forms a signed frequency-control word for a digitally controlled oscillator whose fine capacitor bank moves the output by roughly 12 kHz per unit step, at a nominal divide ratio of 72.

Inside, a proportional term and an accumulated integral term are summed. This places a stabilising zero. The oscillator supplies the second integration, so the closed loop is Type 2. A single-pole IIR section then smooths the sum and gives the loop second-order rolloff. The overall gain, the zero position and the pole position are set at run time: each path has a multiplier and a right shift, and the pole has its own shift. The integrator and the output clip symmetrically and never wrap. A hold input freezes the integral path while the proportional path keeps acting. The control word is registered.

Top module: `dpll_loop_filter`

## Requirements
- R1: A synchronous active-high `rst` clears the integrator and the pole state, so `ctrl_word` reads 0 on the clock edge after any cycle in which `rst` is high.
- R2: `ctrl_word` is registered. Inputs applied before a clock edge first affect `ctrl_word` just after that edge, and changing them between edges leaves `ctrl_word` unchanged.
- R3: The proportional term is floor(e*kp_mult / 2^kp_shift). Here e is `phase_err` read as two's complement, `kp_mult` and `kp_shift` are unsigned, and the shift is arithmetic, so it rounds toward minus infinity.
- R4: On every cycle without hold, the integrator adds floor(e*ki_mult / 2^ki_shift). `ki_mult` and `ki_shift` are unsigned.
- R5: The zero sum is the integrator value after this cycle's update plus this cycle's proportional term. With `pole_shift` = 0, `ctrl_word` equals that sum after clipping.
- R6: The pole section computes y_new = y + floor((xc - y) / 2^pole_shift), where xc is the clipped zero sum. Each new output lies between the previous output and xc, inclusive.
- R7: The integrator saturates at +/-(2^(ACC_W-1)-1) and never wraps. Once it is pinned, it leaves the limit only by later increments of the opposite sign.
- R8: The zero sum is clipped to +/-(2^(OUT_W-1)-1) before the pole section, so `ctrl_word` never leaves that range.
- R9: While `hold` is 1, the integrator keeps its value and the proportional term still reaches the output. After `hold` falls, accumulation resumes from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freeze the integral path |
| phase_err | input | ERR_W | Signed phase-error code, one per cycle |
| kp_mult | input | COEF_W | Unsigned proportional multiplier |
| kp_shift | input | SHIFT_W | Proportional right shift |
| ki_mult | input | COEF_W | Unsigned integral multiplier |
| ki_shift | input | SHIFT_W | Integral right shift |
| pole_shift | input | SHIFT_W | Pole coefficient as a right shift (0 = bypass) |
| ctrl_word | output | OUT_W | Signed oscillator control word |

## Verification
Every result is due exactly one edge after its inputs are applied. The error sample, the coefficients and hold all land in the integrator and the output register on the same edge, and reset clears both on that edge too. The bench drives inputs on the falling edge, advances its reference model once for that drive, and compares `ctrl_word` on the next falling edge, so each comparison covers exactly one rising edge. A dedicated check also samples the output just after new inputs are driven, before the edge, to confirm that no combinational path exists.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

  // Symmetric clip of a signed value to +/-(2^(w-1)-1)
  function automatic logic signed [63:0] clip(input logic signed [63:0] v,
                                              input int unsigned w);
    logic signed [63:0] lim;
    lim = (64'sd1 <<< (w - 1)) - 64'sd1;
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/dlf_gain_path.sv
module dlf_gain_path #(
  parameter int ERR_W   = 10,
  parameter int COEF_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int TERM_W  = 26
) (
  input  logic signed [ERR_W-1:0]  err,
  input  logic        [COEF_W-1:0] coef,
  input  logic        [SHIFT_W-1:0] shamt,
  output logic signed [TERM_W-1:0] term
);
  localparam int PROD_W = ERR_W + COEF_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  assign prod   = err * $signed({1'b0, coef});
  assign scaled = prod >>> shamt;
  assign term   = TERM_W'(scaled);
endmodule

// File: rtl/dlf_integrator.sv
module dlf_integrator #(
  parameter int ACC_W = 24,
  parameter int SUM_W = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  input  logic signed [SUM_W-1:0] inc,
  output logic signed [ACC_W-1:0] acc_now,
  output logic signed [ACC_W-1:0] acc_q
);
  logic signed [SUM_W-1:0] raw_sum;

  assign raw_sum = SUM_W'(acc_q) + inc;
  assign acc_now = hold ? acc_q
                        : ACC_W'(dlf_pkg::clip(64'(raw_sum), ACC_W));

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_now;
  end
endmodule

// File: rtl/dlf_pole_iir.sv
module dlf_pole_iir #(
  parameter int OUT_W   = 16,
  parameter int SUM_W   = 26,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [SUM_W-1:0]  x,
  input  logic        [SHIFT_W-1:0] shamt,
  output logic signed [OUT_W-1:0]  y_q
);
  localparam int DW = OUT_W + 1;

  logic signed [OUT_W-1:0] x_clip;
  logic signed [DW-1:0]    diff;
  logic signed [DW-1:0]    stp;
  logic signed [OUT_W-1:0] y_next;

  assign x_clip = OUT_W'(dlf_pkg::clip(64'(x), OUT_W));
  assign diff   = DW'(x_clip) - DW'(y_q);
  assign stp    = diff >>> shamt;
  assign y_next = OUT_W'(DW'(y_q) + stp);

  always_ff @(posedge clk) begin
    if (rst) y_q <= '0;
    else     y_q <= y_next;
  end
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter #(
  parameter int ERR_W   = 10,
  parameter int COEF_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hold,
  input  logic signed [ERR_W-1:0]   phase_err,
  input  logic        [COEF_W-1:0]  kp_mult,
  input  logic        [SHIFT_W-1:0] kp_shift,
  input  logic        [COEF_W-1:0]  ki_mult,
  input  logic        [SHIFT_W-1:0] ki_shift,
  input  logic        [SHIFT_W-1:0] pole_shift,
  output logic signed [OUT_W-1:0]   ctrl_word
);
  localparam int SUM_W = ACC_W + 2;

  logic signed [SUM_W-1:0] p_term;
  logic signed [SUM_W-1:0] i_inc;
  logic signed [ACC_W-1:0] integ_now;
  logic signed [ACC_W-1:0] integ_q;
  logic signed [SUM_W-1:0] zero_sum;

  dlf_gain_path #(.ERR_W(ERR_W), .COEF_W(COEF_W), .SHIFT_W(SHIFT_W),
                  .TERM_W(SUM_W)) u_prop (
    .err(phase_err), .coef(kp_mult), .shamt(kp_shift), .term(p_term));

  dlf_gain_path #(.ERR_W(ERR_W), .COEF_W(COEF_W), .SHIFT_W(SHIFT_W),
                  .TERM_W(SUM_W)) u_intg (
    .err(phase_err), .coef(ki_mult), .shamt(ki_shift), .term(i_inc));

  dlf_integrator #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .hold(hold), .inc(i_inc),
    .acc_now(integ_now), .acc_q(integ_q));

  // Zero: integral (including this sample) plus proportional
  assign zero_sum = SUM_W'(integ_now) + p_term;

  dlf_pole_iir #(.OUT_W(OUT_W), .SUM_W(SUM_W), .SHIFT_W(SHIFT_W)) u_pole (
    .clk(clk), .rst(rst), .x(zero_sum), .shamt(pole_shift), .y_q(ctrl_word));
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int SHIFT_W = 4,
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 16,
  parameter int SUM_W   = 26
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     hold,
  input logic [SHIFT_W-1:0]       pole_shift,
  input logic signed [OUT_W-1:0]  ctrl_word,
  input logic signed [ACC_W-1:0]  integ_q,
  input logic signed [SUM_W-1:0]  zero_sum
);
  localparam longint ACC_LIM = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint OUT_LIM = (64'sd1 <<< (OUT_W - 1)) - 1;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  logic signed [63:0] c64, i64, xc64;
  assign c64  = 64'(ctrl_word);
  assign i64  = 64'(integ_q);
  assign xc64 = dlf_pkg::clip(64'(zero_sum), OUT_W);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ctrl_word == '0 && integ_q == '0));

  assert_bypass_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && pole_shift == '0) |=> c64 == $past(xc64));

  assert_pole_between_R6: assert property (@(posedge clk) disable iff (rst)
    armed |=> ((c64 >= $past(c64) && c64 <= $past(xc64)) ||
               (c64 <= $past(c64) && c64 >= $past(xc64))));

  assert_int_bound_R7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (i64 <= ACC_LIM && i64 >= -ACC_LIM));

  assert_out_bound_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (c64 <= OUT_LIM && c64 >= -OUT_LIM));

  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && hold) |=> $stable(integ_q));
endmodule

bind dpll_loop_filter dlf_checker #(
  .SHIFT_W(SHIFT_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .pole_shift(pole_shift),
  .ctrl_word(ctrl_word), .integ_q(integ_q), .zero_sum(zero_sum));

// File: tb/dpll_loop_filter_test.sv
`timescale 1ns/1ps
module dpll_loop_filter_test;
  localparam int ERR_W = 10, COEF_W = 8, SHIFT_W = 4, ACC_W = 24, OUT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1, hold = 1'b0;
  logic [ERR_W-1:0] phase_err = '0;
  logic [COEF_W-1:0] kp_mult = '0, ki_mult = '0;
  logic [SHIFT_W-1:0] kp_shift = '0, ki_shift = '0, pole_shift = '0;
  logic signed [OUT_W-1:0] ctrl_word;

  int checks = 0, failures = 0;
  bit done = 0;
  longint m_int = 0, m_out = 0;
  int e_cur = 0;

  always #2.5 clk = ~clk;

  dpll_loop_filter #(.ERR_W(ERR_W), .COEF_W(COEF_W), .SHIFT_W(SHIFT_W),
                     .ACC_W(ACC_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst(rst), .hold(hold), .phase_err(phase_err),
    .kp_mult(kp_mult), .kp_shift(kp_shift), .ki_mult(ki_mult),
    .ki_shift(ki_shift), .pole_shift(pole_shift), .ctrl_word(ctrl_word));

  function automatic longint clipv(longint v, int w);
    longint lim = (longint'(1) <<< (w - 1)) - 1;
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic check(string tag, longint expv);
    longint act = longint'(ctrl_word);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s ctrl_word actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic set_coef(int kp, int kps, int ki, int kis, int a);
    kp_mult = COEF_W'(kp); kp_shift = SHIFT_W'(kps);
    ki_mult = COEF_W'(ki); ki_shift = SHIFT_W'(kis); pole_shift = SHIFT_W'(a);
  endtask

  // Drive at a falling edge, advance model by one edge, compare at next falling edge
  task automatic step(int e, bit h, bit r, string tag);
    longint p, inc, x;
    e_cur = e; phase_err = ERR_W'(e); hold = h; rst = r;
    p   = (longint'(e) * longint'(kp_mult)) >>> kp_shift;
    inc = (longint'(e) * longint'(ki_mult)) >>> ki_shift;
    if (r) begin
      m_int = 0; m_out = 0;
    end else begin
      if (!h) m_int = clipv(m_int + inc, ACC_W);
      x = clipv(m_int + p, OUT_W);
      m_out = m_out + ((x - m_out) >>> pole_shift);
    end
    @(negedge clk);
    check(tag, m_out);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    @(negedge clk);
    // R1: reset clears output regardless of error input
    set_coef(200, 0, 200, 0, 0);
    for (int i = 0; i < 3; i++) step(300, 0, 1, "R1");

    // R2: registered output, no combinational path
    set_coef(1, 0, 0, 0, 0);
    step(0, 0, 0, "R2");
    phase_err = ERR_W'(100); #1;
    check("R2", 0);
    step(100, 0, 0, "R2");
    check("R2", 100);
    step(0, 0, 0, "R2");

    // R3: proportional with floor rounding on negative values
    set_coef(3, 2, 0, 0, 0);
    step(-5, 0, 0, "R3");
    check("R3", -4);
    step(5, 0, 0, "R3");
    check("R3", 3);

    // R4: integral accumulation
    step(0, 0, 1, "R1");
    set_coef(0, 0, 1, 0, 0);
    for (int i = 1; i <= 4; i++) begin
      step(7, 0, 0, "R4");
      check("R4", 7 * i);
    end

    // R5: zero sum uses updated integrator plus proportional
    set_coef(2, 0, 1, 0, 0);
    step(10, 0, 0, "R5");
    check("R5", 28 + 10 + 20);

    // R6: pole section, shift 2, then bypass
    step(0, 0, 1, "R1");
    set_coef(1, 0, 0, 0, 2);
    step(400, 0, 0, "R6");
    check("R6", 100);
    step(400, 0, 0, "R6");
    check("R6", 175);
    for (int i = 0; i < 6; i++) step(-400, 0, 0, "R6");
    pole_shift = '0;
    step(123, 0, 0, "R6");
    check("R6", 123);

    // R7/R8: integrator saturation and recovery without wrap
    step(0, 0, 1, "R1");
    set_coef(0, 0, 255, 0, 0);
    for (int i = 0; i < 80; i++) step(511, 0, 0, "R8");
    check("R8", 32767);
    for (int i = 0; i < 70; i++) step(-512, 0, 0, "R7");
    // R8: negative clip through proportional path
    step(0, 0, 1, "R1");
    set_coef(255, 0, 0, 0, 0);
    step(-512, 0, 0, "R8");
    check("R8", -32767);

    // R9: hold freezes integral, proportional still acts
    step(0, 0, 1, "R1");
    set_coef(1, 0, 1, 0, 0);
    step(20, 0, 0, "R9");
    step(20, 0, 0, "R9");
    step(50, 1, 0, "R9");
    check("R9", 40 + 50);
    step(50, 1, 0, "R9");
    check("R9", 90);
    step(5, 0, 0, "R9");
    check("R9", 45 + 5);

    // Random mix of coefficients, errors and hold
    step(0, 0, 1, "R1");
    for (int blk = 0; blk < 15; blk++) begin
      set_coef(int'($urandom_range(0, 255)), int'($urandom_range(0, 8)),
               int'($urandom_range(0, 255)), int'($urandom_range(0, 10)),
               int'($urandom_range(0, 6)));
      for (int i = 0; i < 200; i++)
        step(int'($urandom_range(0, 1023)) - 512,
             ($urandom_range(0, 9) == 0), ($urandom_range(0, 499) == 0), "R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule